// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block turns a single decoded transfer descriptor into the ordered list of byte-level operations that make up one SMBus transaction. The descriptor gives a 7-bit target address, a read flag, a command-mode flag, a block flag and two 8-bit length fields. A flat transmit buffer comes with it. From these the sequencer chooses the transaction shape: quick command, send byte, receive byte, byte or word read and write, or block read and write. It then issues start, write, read and stop operations one at a time to an abstract byte-level bus engine. That engine handles bit timing and reports the outcome of each operation through a single-cycle acknowledge.

Bytes read from the target are stored in a receive buffer. When the transaction ends, the block reports a status byte, a count of data bytes written after the address, and a count of data bytes read. Errors reported by the bus engine end the transaction early with a stop. Descriptors whose lengths cannot be served are rejected without touching the bus.

Top module: `smb_txn_seq`

## Requirements
- R1: Operation codes on `op_o` are 0 start, 1 write, 2 read, 3 stop; the address goes out as a write of `{addr, rw}` with rw in bit 0. With both lengths zero and command mode off the sequence is start, address (rw = read flag), stop, and both counts are zero.
- R2: With command mode on and the read flag clear, `wlen_i` itself is the only data byte: start, address write, `wlen_i`, stop; the transmitted count is 1.
- R3: With command mode on and the read flag set, the sequence is start, address write, `wlen_i` as command, start, address read, `rlen_i` reads, stop; received bytes land in the receive buffer from byte 0 upward and the received count equals `rlen_i`.
- R4: With command mode off and the read flag clear, `wlen_i` bytes are written from the transmit buffer in index order (byte 0 is the command; a word therefore goes low byte first). With command mode off and the read flag set, the buffer bytes (if any) are written first, then a repeated start, and `rlen_i` bytes are read. If no bytes are written, the address already carries rw = 1.
- R5: During the data reads, `op_nak_o` is 1 on the last read and 0 on every earlier read.
- R6: A block write (block flag, read flag clear) sends buffer byte 0, then the count `wlen_i`-1, then buffer bytes 1 to `wlen_i`-1; the transmitted count is `wlen_i`+1.
- R7: A block read (block flag, read flag set) reads a count byte N with ACK after the command phase. It then reads N data bytes, and the received count is N. If N exceeds `rlen_i`, the sequencer stops at once and sets the oversize bit. If N is 0, it stops with success.
- R8: A descriptor is rejected with status 0x10, no bus operation, and `done_o` one cycle after `go_i` if any of these holds: a block write has `wlen_i` below 2 or above MAX_BLK+1; a block read has `rlen_i` of 0 or above MAX_BLK; another read has `rlen_i` above MAX_BLK; or a buffer write has `wlen_i` above MAX_BLK+1.
- R9: A NAK on any written byte, including the address, is followed directly by a stop. The NAK bit is set and the success bit is clear. The NAK'd byte is not counted.
- R10: Collision, data-low timeout, clock-low timeout and CRC flags on any acknowledge set their own status bits. On an operation other than stop they cause the next operation to be a stop. The faulted operation's byte is not counted.
- R11: Status bits: 0 success, 1 NAK, 2 CRC error, 3 collision, 4 oversize, 5 data-low timeout, 6 clock-low timeout, 7 always 0; success is set exactly when no other bit is.
- R12: After reset the block is idle with zero outputs. `done_o` pulses for one cycle, one cycle after the stop is acknowledged. `busy_o` is high from the cycle after an accepted `go_i` until the done pulse. `go_i` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start a transaction from the descriptor inputs |
| addr_i | input | 7 | Target address |
| rd_i | input | 1 | Read flag |
| cmd_mode_i | input | 1 | Command mode: `wlen_i` is itself the byte sent |
| blk_i | input | 1 | Block transfer |
| wlen_i | input | 8 | Write length or command byte |
| rlen_i | input | 8 | Read length (block read: maximum) |
| tx_buf_i | input | 8*(MAX_BLK+1) | Transmit buffer, byte k at bits 8k+7:8k |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | Completion status |
| tx_cnt_o | output | 8 | Data bytes written after the address |
| rx_cnt_o | output | 8 | Data bytes read |
| rx_buf_o | output | 8*MAX_BLK | Receive buffer, byte k at bits 8k+7:8k |
| op_valid_o | output | 1 | Bus operation request |
| op_o | output | 2 | Operation code |
| op_data_o | output | 8 | Byte to write |
| op_nak_o | output | 1 | Answer this read with NAK |
| op_ack_i | input | 1 | Bus engine completed the operation |
| op_rdata_i | input | 8 | Byte read, valid with ack |
| op_nak_i | input | 1 | Target NAK'd a written byte |
| op_col_i | input | 1 | Collision |
| op_dlto_i | input | 1 | Data-low timeout |
| op_clto_i | input | 1 | Clock-low timeout |
| op_crc_i | input | 1 | CRC error |

## Verification
Each operation is presented in the cycle after the previous one is acknowledged. A transaction of N operations with a zero-wait responder therefore raises `done_o` exactly N+1 cycles after the cycle in which `go_i` is sampled, and a rejection raises it after 1 cycle. The bench responds on the falling edge and records each operation there. It counts falling edges from `go_i` to `done_o` and compares that count with N+1. Status, counts and the receive buffer are read in that same done cycle, while they are held stable.

// File: rtl/smb_txn_pkg.sv
package smb_txn_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_WR, S_RCNT, S_RD, S_STOP, S_DONE
  } seq_state_e;

  localparam int ST_OK   = 0;
  localparam int ST_NAK  = 1;
  localparam int ST_CRC  = 2;
  localparam int ST_COL  = 3;
  localparam int ST_OVR  = 4;
  localparam int ST_DLTO = 5;
  localparam int ST_CLTO = 6;
endpackage

// File: rtl/smb_tx_sel.sv
module smb_tx_sel #(
  parameter int TX_BYTES = 33
) (
  input  logic [TX_BYTES*8-1:0] buf_i,
  input  logic [7:0]            idx_i,
  input  logic                  cmd_i,
  input  logic                  blkw_i,
  input  logic [7:0]            wlen_i,
  output logic [7:0]            byte_o
);
  logic [7:0] bidx;
  logic       from_buf;

  always_comb begin
    bidx     = idx_i;
    from_buf = 1'b1;
    byte_o   = '0;
    if (blkw_i) begin
      if (idx_i == 8'd1)      from_buf = 1'b0;
      else if (idx_i != 8'd0) bidx = idx_i - 8'd1;
    end
    if (cmd_i && !blkw_i) begin
      byte_o = wlen_i;
    end else if (!from_buf) begin
      byte_o = wlen_i - 8'd1;
    end else begin
      for (int k = 0; k < TX_BYTES; k++)
        if (bidx == 8'(k)) byte_o = buf_i[k*8 +: 8];
    end
  end
endmodule

// File: rtl/smb_rx_store.sv
module smb_rx_store #(
  parameter int RX_BYTES = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [7:0]            idx_i,
  input  logic [7:0]            data_i,
  output logic [RX_BYTES*8-1:0] buf_o
);
  for (genvar g = 0; g < RX_BYTES; g++) begin : g_byte
    logic [7:0] q_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        q_r <= '0;
      else if (we_i && idx_i == 8'(g))    q_r <= data_i;
    end
    assign buf_o[g*8 +: 8] = q_r;
  end
endmodule

// File: rtl/smb_seq_ctl.sv
module smb_seq_ctl
  import smb_txn_pkg::*;
#(
  parameter int MAX_BLK  = 32,
  parameter int TX_BYTES = 33,
  parameter int RX_BYTES = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [6:0] addr_i,
  input  logic       rd_i,
  input  logic       cmd_mode_i,
  input  logic       blk_i,
  input  logic [7:0] wlen_i,
  input  logic [7:0] rlen_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] status_o,
  output logic [7:0] tx_cnt_o,
  output logic [7:0] rx_cnt_o,
  output logic       op_valid_o,
  output logic [1:0] op_o,
  output logic [7:0] op_data_o,
  output logic       op_nak_o,
  input  logic       op_ack_i,
  input  logic [7:0] op_rdata_i,
  input  logic       op_nak_i,
  input  logic       op_col_i,
  input  logic       op_dlto_i,
  input  logic       op_clto_i,
  input  logic       op_crc_i,
  output logic [7:0] tx_idx_o,
  output logic       tx_cmd_o,
  output logic       tx_blkw_o,
  output logic [7:0] tx_wlen_o,
  input  logic [7:0] tx_byte_i,
  output logic       rx_we_o,
  output logic [7:0] rx_idx_o,
  output logic [7:0] rx_data_o
);
  localparam logic [7:0] BLK_LIM = 8'(MAX_BLK);
  localparam logic [7:0] TX_LIM  = 8'(TX_BYTES);
  localparam logic [7:0] RX_LIM  = 8'(RX_BYTES);

  seq_state_e st_q;
  logic [6:0] addr_q;
  logic       rd_q, cmd_q, blkw_q, blkr_q, rph_q;
  logic [7:0] wlen_q, wtot_q, rtot_q, idx_q, txc_q, rxc_q, stat_q;

  // descriptor decode at go
  logic       blkw_in, blkr_in, reject;
  logic [7:0] wtot_in;
  always_comb begin
    blkw_in = blk_i & ~rd_i;
    blkr_in = blk_i & rd_i;
    if (blkw_in)      reject = (wlen_i < 8'd2) || (wlen_i > BLK_LIM + 8'd1);
    else if (blkr_in) reject = (rlen_i == 8'd0) || (rlen_i > BLK_LIM);
    else              reject = (rd_i && rlen_i > RX_LIM) || (!cmd_mode_i && wlen_i > TX_LIM);
    if (blkw_in)         wtot_in = wlen_i + 8'd1;
    else if (cmd_mode_i) wtot_in = 8'd1;
    else                 wtot_in = wlen_i;
  end

  logic has_w, has_r;
  assign has_w = (wtot_q != 8'd0);
  assign has_r = rd_q && (rtot_q != 8'd0);

  // operation request
  bus_op_e    op_c;
  logic       val_c, nak_c;
  logic [7:0] dat_c;
  always_comb begin
    val_c = 1'b1;
    op_c  = OP_START;
    dat_c = '0;
    nak_c = 1'b0;
    unique case (st_q)
      S_START: op_c = OP_START;
      S_ADDR: begin
        op_c  = OP_WRITE;
        dat_c = {addr_q, rph_q | (~has_w & rd_q)};
      end
      S_WR: begin
        op_c  = OP_WRITE;
        dat_c = tx_byte_i;
      end
      S_RCNT: op_c = OP_READ;
      S_RD: begin
        op_c  = OP_READ;
        nak_c = (idx_q == rtot_q - 8'd1);
      end
      S_STOP: op_c = OP_STOP;
      default: val_c = 1'b0;
    endcase
  end

  // fault decode
  logic [7:0] fbits;
  logic       fault, fire;
  always_comb begin
    fbits          = '0;
    fbits[ST_NAK]  = op_nak_i & (op_c == OP_WRITE);
    fbits[ST_CRC]  = op_crc_i;
    fbits[ST_COL]  = op_col_i;
    fbits[ST_DLTO] = op_dlto_i;
    fbits[ST_CLTO] = op_clto_i;
  end
  assign fault = |fbits;
  assign fire  = val_c & op_ack_i;

  logic [7:0] fin;
  always_comb begin
    fin = stat_q | fbits;
    if (fin == 8'd0) fin[ST_OK] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      rd_q   <= 1'b0;
      cmd_q  <= 1'b0;
      blkw_q <= 1'b0;
      blkr_q <= 1'b0;
      rph_q  <= 1'b0;
      wlen_q <= '0;
      wtot_q <= '0;
      rtot_q <= '0;
      idx_q  <= '0;
      txc_q  <= '0;
      rxc_q  <= '0;
      stat_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (go_i) begin
          addr_q <= addr_i;
          rd_q   <= rd_i;
          cmd_q  <= cmd_mode_i;
          blkw_q <= blkw_in;
          blkr_q <= blkr_in;
          wlen_q <= wlen_i;
          wtot_q <= wtot_in;
          rtot_q <= rlen_i;
          rph_q  <= 1'b0;
          idx_q  <= '0;
          txc_q  <= '0;
          rxc_q  <= '0;
          if (reject) begin
            stat_q <= 8'(1 << ST_OVR);
            st_q   <= S_DONE;
          end else begin
            stat_q <= '0;
            st_q   <= S_START;
          end
        end
        S_DONE: st_q <= S_IDLE;
        default: if (fire) begin
          if (st_q == S_STOP) begin
            stat_q <= fin;
            st_q   <= S_DONE;
          end else if (fault) begin
            stat_q <= stat_q | fbits;
            st_q   <= S_STOP;
          end else begin
            unique case (st_q)
              S_START: st_q <= S_ADDR;
              S_ADDR: begin
                if (rph_q || (!has_w && has_r)) st_q <= blkr_q ? S_RCNT : S_RD;
                else if (has_w)                 st_q <= S_WR;
                else                            st_q <= S_STOP;
              end
              S_WR: begin
                txc_q <= txc_q + 8'd1;
                if (idx_q == wtot_q - 8'd1) begin
                  idx_q <= '0;
                  if (has_r) begin
                    rph_q <= 1'b1;
                    st_q  <= S_START;
                  end else begin
                    st_q <= S_STOP;
                  end
                end else begin
                  idx_q <= idx_q + 8'd1;
                end
              end
              S_RCNT: begin
                if (op_rdata_i > rtot_q) begin
                  stat_q[ST_OVR] <= 1'b1;
                  st_q <= S_STOP;
                end else if (op_rdata_i == 8'd0) begin
                  st_q <= S_STOP;
                end else begin
                  rtot_q <= op_rdata_i;
                  st_q   <= S_RD;
                end
              end
              S_RD: begin
                rxc_q <= rxc_q + 8'd1;
                idx_q <= idx_q + 8'd1;
                if (idx_q == rtot_q - 8'd1) st_q <= S_STOP;
              end
              default: st_q <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = (st_q == S_DONE);
  assign status_o   = stat_q;
  assign tx_cnt_o   = txc_q;
  assign rx_cnt_o   = rxc_q;
  assign op_valid_o = val_c;
  assign op_o       = op_c;
  assign op_data_o  = dat_c;
  assign op_nak_o   = nak_c;
  assign tx_idx_o   = idx_q;
  assign tx_cmd_o   = cmd_q;
  assign tx_blkw_o  = blkw_q;
  assign tx_wlen_o  = wlen_q;
  assign rx_we_o    = (st_q == S_RD) & fire & ~fault;
  assign rx_idx_o   = idx_q;
  assign rx_data_o  = op_rdata_i;
endmodule

// File: rtl/smb_txn_seq.sv
module smb_txn_seq #(
  parameter int  MAX_BLK  = 32,
  localparam int TX_BYTES = MAX_BLK + 1,
  localparam int RX_BYTES = MAX_BLK
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  go_i,
  input  logic [6:0]            addr_i,
  input  logic                  rd_i,
  input  logic                  cmd_mode_i,
  input  logic                  blk_i,
  input  logic [7:0]            wlen_i,
  input  logic [7:0]            rlen_i,
  input  logic [TX_BYTES*8-1:0] tx_buf_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [7:0]            status_o,
  output logic [7:0]            tx_cnt_o,
  output logic [7:0]            rx_cnt_o,
  output logic [RX_BYTES*8-1:0] rx_buf_o,
  output logic                  op_valid_o,
  output logic [1:0]            op_o,
  output logic [7:0]            op_data_o,
  output logic                  op_nak_o,
  input  logic                  op_ack_i,
  input  logic [7:0]            op_rdata_i,
  input  logic                  op_nak_i,
  input  logic                  op_col_i,
  input  logic                  op_dlto_i,
  input  logic                  op_clto_i,
  input  logic                  op_crc_i
);
  logic [7:0] tx_idx, tx_wlen, tx_byte, rx_idx, rx_data;
  logic       tx_cmd, tx_blkw, rx_we;

  smb_seq_ctl #(
    .MAX_BLK (MAX_BLK),
    .TX_BYTES(TX_BYTES),
    .RX_BYTES(RX_BYTES)
  ) ctl_i (
    .clk_i, .rst_ni, .go_i, .addr_i, .rd_i, .cmd_mode_i, .blk_i, .wlen_i, .rlen_i,
    .busy_o, .done_o, .status_o, .tx_cnt_o, .rx_cnt_o,
    .op_valid_o, .op_o, .op_data_o, .op_nak_o,
    .op_ack_i, .op_rdata_i, .op_nak_i, .op_col_i, .op_dlto_i, .op_clto_i, .op_crc_i,
    .tx_idx_o (tx_idx),
    .tx_cmd_o (tx_cmd),
    .tx_blkw_o(tx_blkw),
    .tx_wlen_o(tx_wlen),
    .tx_byte_i(tx_byte),
    .rx_we_o  (rx_we),
    .rx_idx_o (rx_idx),
    .rx_data_o(rx_data)
  );

  smb_tx_sel #(.TX_BYTES(TX_BYTES)) sel_i (
    .buf_i (tx_buf_i),
    .idx_i (tx_idx),
    .cmd_i (tx_cmd),
    .blkw_i(tx_blkw),
    .wlen_i(tx_wlen),
    .byte_o(tx_byte)
  );

  smb_rx_store #(.RX_BYTES(RX_BYTES)) rx_i (
    .clk_i, .rst_ni,
    .we_i  (rx_we),
    .idx_i (rx_idx),
    .data_i(rx_data),
    .buf_o (rx_buf_o)
  );
endmodule

// File: rtl/smb_txn_seq_chk.sv
module smb_txn_seq_chk
  import smb_txn_pkg::*;
#(
  parameter int RX_BYTES = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] status_o,
  input logic [7:0] rx_cnt_o,
  input logic       op_valid_o,
  input logic [1:0] op_o,
  input logic [7:0] op_data_o,
  input logic       op_nak_o,
  input logic       op_ack_i,
  input logic       op_nak_i
);
  assert_stop_then_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_ack_i && op_o == OP_STOP) |=> done_o);

  assert_done_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !op_valid_o);

  assert_nak_on_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_nak_o |-> (op_valid_o && op_o == OP_READ));

  assert_ok_alone_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o[0]) |-> (status_o[7:1] == 7'd0));

  assert_nak_to_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_ack_i && op_o == OP_WRITE && op_nak_i) |=> (op_valid_o && op_o == OP_STOP));

  assert_op_held_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !op_ack_i) |=> (op_valid_o && $stable(op_o) && $stable(op_data_o)));

  assert_rx_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(rx_cnt_o) <= RX_BYTES);
endmodule

bind smb_txn_seq smb_txn_seq_chk #(.RX_BYTES(RX_BYTES)) chk_i (.*);

// File: tb/smb_txn_seq_tb.sv
module smb_txn_seq_tb_top;
  localparam int MB  = 32;
  localparam int TXB = MB + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic go = 0, rd = 0, cmd = 0, blk = 0;
  logic [6:0] addr = 0;
  logic [7:0] wlen = 0, rlen = 0;
  logic [TXB*8-1:0] txbuf;
  logic busy, done, opv, opnak;
  logic [7:0] stat, txc, rxc, opd;
  logic [1:0] op;
  logic [MB*8-1:0] rxbuf;
  logic ack = 0, nak = 0, col = 0, dlto = 0, clto = 0, crc = 0;
  logic [7:0] rdat = 0;

  smb_txn_seq #(.MAX_BLK(MB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .addr_i(addr), .rd_i(rd),
    .cmd_mode_i(cmd), .blk_i(blk), .wlen_i(wlen), .rlen_i(rlen), .tx_buf_i(txbuf),
    .busy_o(busy), .done_o(done), .status_o(stat), .tx_cnt_o(txc), .rx_cnt_o(rxc),
    .rx_buf_o(rxbuf), .op_valid_o(opv), .op_o(op), .op_data_o(opd), .op_nak_o(opnak),
    .op_ack_i(ack), .op_rdata_i(rdat), .op_nak_i(nak), .op_col_i(col),
    .op_dlto_i(dlto), .op_clto_i(clto), .op_crc_i(crc));

  int errs = 0, total = 0;
  int log_n = 0, rd_k = 0, fault_at = 99, fault_kind = 0;
  logic [7:0] blk_n = 0;
  int l_op [80];
  logic [7:0] l_dat [80];
  logic l_nak [80];
  int e_op [80], e_kind [80], e_n;
  logic [7:0] e_dat [80];
  logic e_nak [80];
  logic [7:0] e_stat, e_tx, e_rx;
  logic [7:0] e_rxd [MB];

  function automatic logic [7:0] rbyte(int k);
    if (blk && rd && k == 0) return blk_n;
    return 8'(8'h31 + k * 5);
  endfunction

  // zero-wait bus responder, falling edge
  initial forever begin
    @(negedge clk);
    if (opv && log_n < 80) begin
      l_op[log_n] = int'(op); l_dat[log_n] = opd; l_nak[log_n] = opnak;
      ack = 1;
      nak  = (fault_at == log_n) && fault_kind == 1;
      col  = (fault_at == log_n) && fault_kind == 2;
      dlto = (fault_at == log_n) && fault_kind == 3;
      clto = (fault_at == log_n) && fault_kind == 4;
      crc  = (fault_at == log_n) && fault_kind == 5;
      rdat = 0;
      if (op == 2'd2) begin rdat = rbyte(rd_k); rd_k++; end
      log_n++;
    end else begin
      ack = 0; nak = 0; col = 0; dlto = 0; clto = 0; crc = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int o, input logic [7:0] d, input logic nk, input int kd);
    e_op[e_n] = o; e_dat[e_n] = d; e_nak[e_n] = nk; e_kind[e_n] = kd; e_n++;
  endtask

  task automatic build_exp();
    int wl, nr, lim, j;
    bit blkw, hasr, rej, ovr;
    logic [7:0] b, fb;
    e_n = 0; e_tx = 0; e_rx = 0; ovr = 0; fb = 0;
    blkw = blk && !rd;
    wl = blkw ? int'(wlen) + 1 : (cmd ? 1 : int'(wlen));
    hasr = rd && rlen != 0;
    if (blkw)          rej = wlen < 2 || wlen > MB + 1;
    else if (blk && rd) rej = rlen == 0 || rlen > MB;
    else               rej = (rd && rlen > MB) || (!cmd && wlen > MB + 1);
    if (rej) begin e_stat = 8'h10; return; end
    push(0, 0, 0, 0);
    push(1, {addr, (wl == 0) ? rd : 1'b0}, 0, 0);
    for (int k = 0; k < wl; k++) begin
      if (blkw) b = (k == 0) ? txbuf[7:0] : (k == 1) ? wlen - 8'd1 : txbuf[(k-1)*8 +: 8];
      else if (cmd) b = wlen;
      else b = txbuf[k*8 +: 8];
      push(1, b, 0, 1);
    end
    if (hasr) begin
      if (wl > 0) begin push(0, 0, 0, 0); push(1, {addr, 1'b1}, 0, 0); end
      nr = int'(rlen);
      if (blk) begin
        push(2, 0, 0, 2);
        if (blk_n > rlen) begin ovr = 1; nr = 0; end else nr = int'(blk_n);
      end
      for (int k = 0; k < nr; k++) push(2, 0, k == nr - 1, 3);
    end
    push(3, 0, 0, 0);
    lim = e_n;
    if (fault_at < e_n) begin
      fb = (fault_kind == 1) ? 8'h02 : (fault_kind == 2) ? 8'h08 : (fault_kind == 3) ? 8'h20 :
           (fault_kind == 4) ? 8'h40 : 8'h04;
      lim = fault_at;
      if (fault_at < e_n - 1) begin e_n = fault_at + 1; push(3, 0, 0, 0); end
    end
    j = 0;
    for (int k = 0; k < lim; k++) begin
      if (e_kind[k] == 1) e_tx++;
      if (e_kind[k] == 3) begin e_rxd[j] = rbyte(j + (blk ? 1 : 0)); j++; e_rx++; end
    end
    e_stat = (ovr ? 8'h10 : 8'h00) | fb;
    if (e_stat == 0) e_stat = 8'h01;
  endtask

  task automatic run(input string tag, input bit poke = 0);
    int lat, bad;
    log_n = 0; rd_k = 0;
    build_exp();
    @(negedge clk); go = 1;
    @(negedge clk); go = 0; lat = 1;
    while (!done && lat < 300) begin
      if (poke && lat == 3) begin go = 1; addr = addr ^ 7'h55; end
      if (poke && lat == 4) begin go = 0; addr = addr ^ 7'h55; end
      @(negedge clk); lat++;
    end
    chk(lat == e_n + 1, tag, "done latency", lat, e_n + 1);
    bad = -1;
    for (int k = 0; k < e_n; k++)
      if (bad < 0 && (k >= log_n || l_op[k] != e_op[k] || (e_op[k] == 1 && l_dat[k] != e_dat[k]) ||
          (e_op[k] == 2 && l_nak[k] != e_nak[k]))) bad = k;
    if (bad < 0 && log_n != e_n) bad = e_n;
    if (bad >= 0 && bad < e_n && bad < log_n)
      chk(0, tag, $sformatf("op %0d {op,data,nak}", bad), {l_op[bad][1:0], l_dat[bad], l_nak[bad]},
          {e_op[bad][1:0], e_dat[bad], e_nak[bad]});
    else chk(bad < 0, tag, "op count", log_n, e_n);
    chk(stat == e_stat, tag, "status", stat, e_stat);
    chk(txc == e_tx, tag, "tx count", txc, e_tx);
    chk(rxc == e_rx, tag, "rx count", rxc, e_rx);
    bad = -1;
    for (int k = 0; k < int'(e_rx); k++) if (bad < 0 && rxbuf[k*8 +: 8] != e_rxd[k]) bad = k;
    chk(bad < 0, tag, "rx data", (bad < 0) ? 0 : rxbuf[bad*8 +: 8], (bad < 0) ? 0 : e_rxd[bad]);
    repeat (2) @(negedge clk);
  endtask

  task automatic desc(input logic [6:0] a, input logic r, input logic c, input logic b,
                      input logic [7:0] w, input logic [7:0] l);
    addr = a; rd = r; cmd = c; blk = b; wlen = w; rlen = l;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    for (int k = 0; k < TXB; k++) txbuf[k*8 +: 8] = 8'(8'h50 + k * 3);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !opv && stat == 0 && txc == 0 && rxc == 0 && rxbuf == '0,
        "R12", "reset outputs", {busy, done, opv}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 quick command
    foreach (addr_vals[i]) begin desc(addr_vals[i], 0, 0, 0, 0, 0); run("R1"); desc(addr_vals[i], 1, 0, 0, 0, 0); run("R1"); end
    // R2 send byte
    foreach (byte_vals[i]) begin desc(7'h2C, 0, 1, 0, byte_vals[i], 0); run("R2"); end
    // R3 R5 command then read
    for (int l = 0; l <= 4; l++) begin desc(7'h48, 1, 1, 0, 8'h9A, 8'(l)); run("R3 R5"); end
    desc(7'h48, 1, 1, 0, 8'h11, 8'd32); run("R3 R5");
    // R4 buffer writes and reads
    for (int w = 1; w <= 4; w++) begin desc(7'h50, 0, 0, 0, 8'(w), 0); run("R4"); end
    desc(7'h51, 1, 0, 0, 0, 1); run("R4 R5");
    desc(7'h51, 1, 0, 0, 1, 2); run("R4 R5");
    desc(7'h52, 0, 0, 0, 8'd33, 0); run("R4");
    // R6 block writes, every legal count
    for (int w = 2; w <= MB + 1; w++) begin desc(7'h33, 0, 0, 1, 8'(w), 0); run("R6"); end
    // R8 rejections
    foreach (rej_w[i]) begin desc(7'h33, 0, 0, 1, rej_w[i], 0); run("R8"); end
    desc(7'h33, 1, 1, 1, 8'h07, 0); run("R8");
    desc(7'h33, 1, 1, 1, 8'h07, 8'd33); run("R8");
    desc(7'h33, 1, 1, 0, 8'h07, 8'd33); run("R8");
    desc(7'h33, 0, 0, 0, 8'd34, 0); run("R8");
    // R7 block reads, every count up to the limit
    for (int n = 0; n <= MB; n++) begin blk_n = 8'(n); desc(7'h3A, 1, 1, 1, 8'h40, 8'd32); run("R7 R5"); end
    blk_n = 8'd5; desc(7'h3A, 1, 1, 1, 8'h40, 8'd4); run("R7 R11");
    blk_n = 8'd4; desc(7'h3A, 1, 1, 1, 8'h40, 8'd4); run("R7");
    // R9 NAK at address and every data byte
    fault_kind = 1;
    for (int f = 1; f <= 4; f++) begin fault_at = f; desc(7'h60, 0, 0, 0, 8'd3, 0); run("R9 R11"); end
    // R10 other faults
    fault_kind = 2; fault_at = 0; desc(7'h61, 0, 0, 0, 8'd2, 0); run("R10 R11");
    fault_kind = 3; fault_at = 2; desc(7'h61, 0, 0, 0, 8'd2, 0); run("R10 R11");
    fault_kind = 4; fault_at = 4; desc(7'h61, 0, 0, 0, 8'd2, 0); run("R10 R11");
    fault_kind = 5; fault_at = 5; desc(7'h62, 1, 1, 0, 8'h05, 8'd2); run("R10 R11");
    fault_kind = 0; fault_at = 99;
    // R12 go while busy is ignored
    desc(7'h70, 0, 0, 0, 8'd4, 0); run("R12", 1);
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  logic [6:0] addr_vals [3] = '{7'h00, 7'h5A, 7'h7F};
  logic [7:0] byte_vals [3] = '{8'h00, 8'hA5, 8'hFF};
  logic [7:0] rej_w [3] = '{8'd0, 8'd1, 8'd34};
endmodule